// File: doc/BRIEF.md
# DSP Reset Release and Boot Start Sequencer

This block brings a DSP core out of reset in a fixed order. While the external reset is low it holds three core controls high: one that empties every stack pointer, one that masks every interrupt source, and one that clears the mode/status register to zero. Reset takes effect at once, without waiting for a clock edge. Its release passes through a synchroniser, and the block then chooses between a boot load and a direct start.

A boot load runs only when the memory-map strap is 0 and no external bus request is pending. If a request is pending at release, the block parks in a bus-wait phase. When the request drops, it evaluates the strap again. A boot load is a one-cycle start pulse to an external loader, followed by a wait for the loader's done input. While booting, the two upper data-bus lines pass through to the two upper boot-memory address lines, which larger boot memories need. The block then enables the core and issues a one-cycle first-fetch pulse with the internal program address fixed at zero. A phase output always shows where the sequence stands.

Top module: `reset_boot_seq`

## Requirements
- R1: While `rst_n` is low, and from that moment without waiting for a clock edge, `stack_clr`, `irq_mask_all` and `stat_clr` are 1 and `phase` is 0 (reset). All three controls are 0 in every other phase.
- R2: After `rst_n` rises, `phase` stays 0 through the first SYNC_STAGES rising clock edges. It leaves 0 on edge SYNC_STAGES+1, the decision edge.
- R3: If `bus_req` is 0 and `map_strap` is 0 at the decision edge, `phase` becomes 2 (boot) and `boot_start` is 1 for exactly that one cycle.
- R4: If `bus_req` is 0 and `map_strap` is 1 at the decision edge, `phase` becomes 3 (run) directly and `boot_start` stays 0.
- R5: If `bus_req` is 1 at the decision edge, `phase` becomes 1 (bus wait). It stays 1 on every edge where `bus_req` is 1. The first edge with `bus_req` 0 is a new decision edge, where R3 or R4 applies with `map_strap` sampled on that edge.
- R6: In phase 2, an edge with `boot_done` 1 moves `phase` to 3. Phase 3 is held until reset.
- R7: `fetch_go` is 1 for exactly the one cycle after entry into phase 3, and `fetch_addr` is 0.
- R8: `boot_addr_hi` equals `boot_data_hi` while `phase` is 2 and is 0 otherwise.
- R9: `core_run` is 1 exactly when `phase` is 3.
- R10: Asserting `rst_n` in any phase returns `phase` to 0 and raises the R1 controls at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | External reset, active low, asynchronous assertion |
| map_strap | input | 1 | Memory-map strap; 0 permits a boot load |
| bus_req | input | 1 | External bus request; 1 defers the start decision |
| boot_done | input | 1 | Loader reports that the boot load is complete |
| boot_data_hi | input | BOOT_HI_W | Upper data-bus lines used as upper boot address bits |
| stack_clr | output | 1 | Forces all stack pointers to empty |
| irq_mask_all | output | 1 | Masks every interrupt source |
| stat_clr | output | 1 | Clears the mode/status register |
| boot_start | output | 1 | One-cycle start pulse to the loader |
| boot_addr_hi | output | BOOT_HI_W | Upper boot-memory address bits |
| core_run | output | 1 | Core run enable |
| fetch_go | output | 1 | One-cycle first-fetch request |
| fetch_addr | output | ADDR_W | First-fetch address, always zero |
| phase | output | 2 | 0 reset, 1 bus wait, 2 boot, 3 run |

## Verification
The bench uses the default SYNC_STAGES of 2, ADDR_W of 14 and BOOT_HI_W of 2. These settings keep the release latency to three edges and make every value of the upper boot address lines a small known pattern. On that setting it sweeps every combination of the strap at release, the strap at the deferred decision, bus-request lengths of zero to three cycles and done delays of zero to three cycles. That sweep reaches every phase path, including a strap that changes while the bus request is held. Each case starts by reasserting reset in the middle of the run phase, so the asynchronous return to phase 0 is checked on every pass.

// File: rtl/reset_boot_seq.sv
module reset_boot_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 14,
  parameter int BOOT_HI_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 map_strap,
  input  logic                 bus_req,
  input  logic                 boot_done,
  input  logic [BOOT_HI_W-1:0] boot_data_hi,
  output logic                 stack_clr,
  output logic                 irq_mask_all,
  output logic                 stat_clr,
  output logic                 boot_start,
  output logic [BOOT_HI_W-1:0] boot_addr_hi,
  output logic                 core_run,
  output logic                 fetch_go,
  output logic [ADDR_W-1:0]    fetch_addr,
  output logic [1:0]           phase
);

  typedef enum logic [1:0] {PH_RESET = 2'd0, PH_WAIT = 2'd1, PH_BOOT = 2'd2, PH_RUN = 2'd3} phase_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rel;
  phase_t                 cur, nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};

  assign rel = sync_q[SYNC_STAGES-1];

  always_comb begin
    nxt = cur;
    case (cur)
      PH_RESET, PH_WAIT:
        if (bus_req)         nxt = PH_WAIT;
        else if (!map_strap) nxt = PH_BOOT;
        else                 nxt = PH_RUN;
      PH_BOOT: if (boot_done) nxt = PH_RUN;
      default: nxt = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur        <= PH_RESET;
      boot_start <= 1'b0;
      fetch_go   <= 1'b0;
    end else if (!rel) begin
      cur        <= PH_RESET;
      boot_start <= 1'b0;
      fetch_go   <= 1'b0;
    end else begin
      cur        <= nxt;
      boot_start <= (nxt == PH_BOOT) && (cur != PH_BOOT);
      fetch_go   <= (nxt == PH_RUN) && (cur != PH_RUN);
    end

  assign stack_clr    = (cur == PH_RESET);
  assign irq_mask_all = (cur == PH_RESET);
  assign stat_clr     = (cur == PH_RESET);
  assign boot_addr_hi = (cur == PH_BOOT) ? boot_data_hi : '0;
  assign core_run     = (cur == PH_RUN);
  assign fetch_addr   = '0;
  assign phase        = cur;

endmodule

// File: rtl/reset_boot_seq_chk.sv
module reset_boot_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       boot_done,
  input logic       stack_clr,
  input logic       irq_mask_all,
  input logic       stat_clr,
  input logic       boot_start,
  input logic       addr_hi_zero,
  input logic       core_run,
  input logic       fetch_go,
  input logic [1:0] phase
);

  p_ctrl_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |-> (stack_clr && irq_mask_all && stat_clr));

  p_ctrl_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd0) |-> !(stack_clr || irq_mask_all || stat_clr));

  p_start_in_boot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    boot_start |-> (phase == 2'd2));

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    boot_start |=> !boot_start);

  p_hold_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && bus_req) |=> (phase == 2'd1));

  p_boot_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && boot_done) |=> (phase == 2'd3));

  p_run_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3) |=> (phase == 2'd3));

  p_fetch_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> core_run);

  p_fetch_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> !fetch_go);

  p_addr_hi_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd2) |-> addr_hi_zero);

endmodule

bind reset_boot_seq reset_boot_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .boot_done(boot_done),
  .stack_clr(stack_clr), .irq_mask_all(irq_mask_all), .stat_clr(stat_clr),
  .boot_start(boot_start), .addr_hi_zero(boot_addr_hi == '0),
  .core_run(core_run), .fetch_go(fetch_go), .phase(phase)
);

// File: tb/test_reset_boot_seq.sv
`timescale 1ns/1ps
module test_reset_boot_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0, map_strap = 1'b0, bus_req = 1'b0, boot_done = 1'b0;
  logic [1:0] boot_data_hi = 2'd0;
  logic stack_clr, irq_mask_all, stat_clr, boot_start, core_run, fetch_go;
  logic [1:0] boot_addr_hi, phase;
  logic [13:0] fetch_addr;
  int runs = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  reset_boot_seq i_reset_boot_seq (
    .clk(clk), .rst_n(rst_n), .map_strap(map_strap), .bus_req(bus_req),
    .boot_done(boot_done), .boot_data_hi(boot_data_hi),
    .stack_clr(stack_clr), .irq_mask_all(irq_mask_all), .stat_clr(stat_clr),
    .boot_start(boot_start), .boot_addr_hi(boot_addr_hi), .core_run(core_run),
    .fetch_go(fetch_go), .fetch_addr(fetch_addr), .phase(phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_phase(input string req, input int exp);
    chk(req, phase, exp);
    chk({req, "/R9 run"}, core_run, exp == 3);
    chk({req, "/R1 ctl"}, {stack_clr, irq_mask_all, stat_clr}, (exp == 0) ? 7 : 0);
  endtask

  task automatic run_case(input bit s_rel, input bit s_dec, input int req_n, input int done_n);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_phase("R10 async reset", 0);
    map_strap = s_rel;
    bus_req = (req_n > 0);
    boot_done = 1'b0;
    if (req_n == 0) map_strap = s_dec;
    repeat (3) @(negedge clk);
    chk_phase("R1 held", 0);
    rst_n = 1'b1;
    @(negedge clk); chk_phase("R2 edge1", 0);
    @(negedge clk); chk_phase("R2 edge2", 0);
    for (int i = 0; i < req_n; i++) begin
      boot_data_hi = 2'(i + 1);
      @(negedge clk);
      chk_phase("R5 wait", 1);
      chk("R8 idle hi", boot_addr_hi, 0);
      chk("R3 no start", boot_start, 0);
      if (i == req_n - 1) begin
        bus_req = 1'b0;
        map_strap = s_dec;
      end
    end
    boot_data_hi = 2'd3;
    @(negedge clk);
    if (!s_dec) begin
      chk_phase("R3 boot", 2);
      chk("R3 start pulse", boot_start, 1);
      chk("R8 pass hi", boot_addr_hi, 3);
      chk("R7 no fetch", fetch_go, 0);
      for (int d = 0; d < done_n; d++) begin
        boot_data_hi = 2'(d);
        @(negedge clk);
        chk_phase("R6 boot wait", 2);
        chk("R3 start once", boot_start, 0);
        chk("R8 pass hi", boot_addr_hi, d);
      end
      boot_done = 1'b1;
      @(negedge clk);
      boot_done = 1'b0;
    end else begin
      chk("R4 no start", boot_start, 0);
    end
    chk_phase("R4/R6 run", 3);
    chk("R7 fetch pulse", fetch_go, 1);
    chk("R7 fetch addr", fetch_addr, 0);
    chk("R8 run hi", boot_addr_hi, 0);
    @(negedge clk);
    chk("R7 fetch once", fetch_go, 0);
    chk_phase("R6 stays run", 3);
    boot_done = 1'b1;
    @(negedge clk);
    boot_done = 1'b0;
    chk_phase("R6 run ignores done", 3);
  endtask

  initial begin
    #1;
    chk_phase("R1 reset state", 0);
    chk("R3 reset start", boot_start, 0);
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < 4; r++)
          for (int d = 0; d < 4; d++)
            run_case(a[0], b[0], r, d);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      runs++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule